// File: doc/BRIEF.md
# Dual-Link Odd/Even Pixel Splitter

This block takes one parallel RGB pixel stream, 8 bits per colour with horizontal sync, vertical sync and data enable, and divides it into two half-rate streams that feed a dual-link LVDS-style display output. The first pixel of each pair goes to link A and the second goes to link B. Each link puts out four data lanes and one forwarded clock lane, and each lane carries seven serial bits per link clock period.

Everything runs on one clock, `clk`. A pixel is accepted on any cycle with `pix_ce` high, and one serial bit time passes on any cycle with `bit_ce` high. The link clock runs at half the pixel rate, so the surrounding logic issues two `pix_ce` strobes for every seven `bit_ce` strobes. A finished pair waits in a one-entry holding stage and is loaded into both links at the next word boundary. The pairing is re-anchored at every rising edge of data enable, so the first active pixel of a line always goes to link A.

Top module: `dual_link_splitter`

## Requirements
- R1: After reset, every data lane and both link clocks stay 0 until the first pixel accepted with `de`=1 whose previous accepted pixel had `de`=0. The next `bit_ce` cycle after that pixel starts the first word.
- R2: Once started, each link clock repeats the pattern 1,1,0,0,0,1,1 over the seven bit times of every word, without a break. That is 4 bit times high and 3 low, at half the pixel rate.
- R3: The pixel that raises `de` is the odd pixel and goes to link A. After it, accepted pixels alternate even (link B) and odd (link A).
- R4: Lane words are sent MSB first, bit 6 in the first bit time of the word, and they are aligned with the clock pattern. Lane 0 is R[7:1]. Lane 1 is G[7:1]. Lane 2 is {B[7:4],HS,VS,DE}. Lane 3 is {R[0],G[0],B[3:0],0}.
- R5: On both links, lane 2 carries the HS and VS of the odd pixel of the pair. The DE bit of link B is the DE of the even pixel.
- R6: When the odd pixel has DE=1 and its even partner has DE=0, link B sends zero colour bits and DE=0, and keeps the HS and VS of the odd pixel.
- R7: When DE rises on what would be an even slot, the pending unpaired blanking pixel is discarded and never appears on either link.
- R8: A completed pair is shown on both links for exactly one word, the word that starts at the first word boundary after the pair completes. A word that starts with no pair waiting carries all-zero data and still carries the clock pattern.
- R9: Cycles with `bit_ce`=0 leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the pixel and bit domains |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Accepts the pixel present on r, g, b, hs, vs, de |
| r | input | 8 | Red component |
| g | input | 8 | Green component |
| b | input | 8 | Blue component |
| hs | input | 1 | Horizontal sync |
| vs | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| bit_ce | input | 1 | Advances one serial bit time |
| a_dat | output | 4 | Link A data lanes (odd pixels) |
| a_lclk | output | 1 | Link A forwarded clock lane |
| b_dat | output | 4 | Link B data lanes (even pixels) |
| b_lclk | output | 1 | Link B forwarded clock lane |

## Verification
The stimulus covers five patterns:
- A line with an even number of active pixels, which separates correct odd/even routing and lane mapping from swapped or shifted assignments.
- A line with an odd number of active pixels, which exposes the zero fill of the unpaired even slot.
- A line whose DE rise falls on an even slot, which shows whether the pairing is re-anchored or simply keeps alternating.
- Idle stretches with no pixels, which check the zero-data words and an unbroken clock pattern.
- A run with `bit_ce` at half duty and a matching pixel rate, which checks that gated cycles freeze the outputs.

Blanking pixels sent before the first DE rise check that the outputs stay silent until the start condition.

// File: rtl/dual_link_splitter.sv
module dual_link_splitter (
  input  logic       clk,
  input  logic       rst,
  input  logic       pix_ce,
  input  logic [7:0] r,
  input  logic [7:0] g,
  input  logic [7:0] b,
  input  logic       hs,
  input  logic       vs,
  input  logic       de,
  input  logic       bit_ce,
  output logic [3:0] a_dat,
  output logic       a_lclk,
  output logic [3:0] b_dat,
  output logic       b_lclk
);

  localparam int WORD = 7;
  localparam int NLANE = 4;
  localparam logic [WORD-1:0] CLK_PAT = 7'b1100011;

  typedef logic [NLANE-1:0][WORD-1:0] word_t;

  function automatic word_t pack(input logic [7:0] pr, input logic [7:0] pg,
                                 input logic [7:0] pb, input logic phs,
                                 input logic pvs, input logic pde);
    word_t w;
    w[0] = pr[7:1];
    w[1] = pg[7:1];
    w[2] = {pb[7:4], phs, pvs, pde};
    w[3] = {pr[0], pg[0], pb[3:0], 1'b0};
    return w;
  endfunction

  logic       de_q, ph, run, live, hold_vld;
  logic [2:0] cnt;
  word_t      odd_q, hold_a, hold_b, sh_a, sh_b, even_w;

  wire rise      = pix_ce & de & ~de_q;
  wire pair_done = pix_ce & run & ph & ~rise;
  wire load      = bit_ce & run & (~live | (cnt == 3'd6));
  wire unpaired  = odd_q[2][0] & ~de;
  wire [2:0] bsel = 3'd6 - cnt;

  assign even_w = unpaired ? pack(8'd0, 8'd0, 8'd0, odd_q[2][2], odd_q[2][1], 1'b0)
                           : pack(r, g, b, odd_q[2][2], odd_q[2][1], de);

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q     <= 1'b0;
      ph       <= 1'b0;
      run      <= 1'b0;
      live     <= 1'b0;
      hold_vld <= 1'b0;
      cnt      <= 3'd0;
      odd_q    <= '0;
      hold_a   <= '0;
      hold_b   <= '0;
      sh_a     <= '0;
      sh_b     <= '0;
    end else begin
      if (pix_ce) begin
        de_q <= de;
        if (rise) run <= 1'b1;
        if (run || rise) begin
          if (rise || !ph) begin
            odd_q <= pack(r, g, b, hs, vs, de);
            ph    <= 1'b1;
          end else begin
            hold_a <= odd_q;
            hold_b <= even_w;
            ph     <= 1'b0;
          end
        end
      end
      if (pair_done) hold_vld <= 1'b1;
      else if (load) hold_vld <= 1'b0;
      if (load) begin
        sh_a <= hold_vld ? hold_a : '0;
        sh_b <= hold_vld ? hold_b : '0;
        cnt  <= 3'd0;
        live <= 1'b1;
      end else if (bit_ce && live) begin
        cnt <= cnt + 3'd1;
      end
    end
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign a_dat[i] = live & sh_a[i][bsel];
    assign b_dat[i] = live & sh_b[i][bsel];
  end

  assign a_lclk = live & CLK_PAT[bsel];
  assign b_lclk = live & CLK_PAT[bsel];

  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!live && a_dat == 4'd0 && b_dat == 4'd0));

  p_lclk_edge_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(a_lclk) |-> (cnt == 3'd5 || cnt == 3'd0));

  p_odd_anchor_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> ph);

  p_no_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (pair_done && hold_vld) |-> load);

  p_gate_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (live && !bit_ce) |=> ($stable(cnt) && $stable(a_dat) && $stable(b_dat) && $stable(a_lclk)));

endmodule

// File: tb/dual_link_splitter_tb.sv
module dual_link_splitter_tb;
  logic clk = 1'b0;
  logic rst, pix_ce, hs, vs, de, bit_ce;
  logic [7:0] r, g, b;
  logic [3:0] a_dat, b_dat;
  logic a_lclk, b_lclk;

  always #10 clk = ~clk;

  dual_link_splitter u_dut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .r(r), .g(g), .b(b),
    .hs(hs), .vs(vs), .de(de), .bit_ce(bit_ce),
    .a_dat(a_dat), .a_lclk(a_lclk), .b_dat(b_dat), .b_lclk(b_lclk));

  int compared = 0, mismatched = 0, cyc = 0;
  bit slow = 0, done = 0, gap_t = 0;
  string scen = "R1";

  logic [55:0] q[$];
  logic [27:0] cur_a = '0, cur_b = '0;
  int  m_cnt = 0;
  bit  m_deq = 0, m_ph = 0, m_run = 0, m_live = 0;
  logic [7:0] o_r, o_g, o_b;
  logic o_hs, o_vs, o_de;

  function automatic logic [27:0] lanes(input logic [7:0] cr, cg, cb, input logic s_h, s_v, s_d);
    logic [6:0] l0, l1, l2, l3;
    l0 = cr >> 1;
    l1 = cg >> 1;
    l2 = {cb[7:4], s_h, s_v, s_d};
    l3 = {cr[0], cg[0], cb[3:0], 1'b0};
    return {l3, l2, l1, l0};
  endfunction

  task automatic model_step();
    bit ld, rs;
    logic [55:0] e;
    ld = bit_ce && m_run && (!m_live || m_cnt == 6);
    if (ld) begin
      if (q.size() > 0) e = q.pop_front(); else e = '0;
      cur_a = e[55:28]; cur_b = e[27:0];
      m_cnt = 0; m_live = 1;
    end else if (bit_ce && m_live) m_cnt++;
    if (pix_ce) begin
      rs = de && !m_deq;
      if (m_run || rs) begin
        if (rs || !m_ph) begin
          o_r = r; o_g = g; o_b = b; o_hs = hs; o_vs = vs; o_de = de; m_ph = 1;
        end else begin
          if (o_de && !de) q.push_back({lanes(o_r, o_g, o_b, o_hs, o_vs, o_de), lanes(0, 0, 0, o_hs, o_vs, 0)});
          else q.push_back({lanes(o_r, o_g, o_b, o_hs, o_vs, o_de), lanes(r, g, b, o_hs, o_vs, de)});
          m_ph = 0;
        end
      end
      if (rs) m_run = 1;
      m_deq = de;
    end
  endtask

  task automatic compare();
    logic [3:0] ea, eb;
    logic ec;
    for (int i = 0; i < 4; i++) begin
      ea[i] = m_live ? cur_a[7*i + 6 - m_cnt] : 1'b0;
      eb[i] = m_live ? cur_b[7*i + 6 - m_cnt] : 1'b0;
    end
    ec = m_live && (m_cnt < 2 || m_cnt > 4);
    compared++;
    if (a_lclk !== ec || b_lclk !== ec) begin
      mismatched++;
      $display("FAIL R2 cyc %0d lclk a=%b b=%b expected %b", cyc, a_lclk, b_lclk, ec);
    end
    if (a_dat !== ea || b_dat !== eb) begin
      mismatched++;
      $display("FAIL %s cyc %0d a_dat=%b b_dat=%b expected %b %b", m_live ? scen : "R1", cyc, a_dat, b_dat, ea, eb);
    end
  endtask

  task automatic tick(input bit pce);
    pix_ce = pce;
    bit_ce = slow ? cyc[0] : 1'b1;
    @(posedge clk);
    if (!rst) model_step();
    @(negedge clk);
    cyc++;
    if (!rst) compare();
  endtask

  task automatic px(input logic [7:0] pr, pg, pb, input logic phs, pvs, pde);
    int gap;
    r = pr; g = pg; b = pb; hs = phs; vs = pvs; de = pde;
    gap = slow ? 7 : (gap_t ? 4 : 3);
    gap_t = !gap_t;
    tick(1);
    repeat (gap - 1) tick(0);
  endtask

  task automatic line(input int nact, input int nblank, input int seed);
    for (int k = 0; k < nact; k++)
      px(8'(seed*37 + k*29 + 5), 8'(seed*11 + k*53 + 1), 8'(seed*71 + k*17 + 9), 1'b0, k[0], 1'b1);
    for (int k = 0; k < nblank; k++)
      px(8'(k*13 + 2), 8'(k*7 + 3), 8'(k*19 + 4), 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1; pix_ce = 0; bit_ce = 0; r = 0; g = 0; b = 0; hs = 0; vs = 0; de = 0;
    repeat (4) tick(0);
    rst = 0;
    tick(0);
    scen = "R1";
    line(0, 6, 0);
    scen = "R3 R4 R5 R8";
    line(8, 6, 1);
    scen = "R6";
    line(7, 5, 2);
    scen = "R7";
    line(0, 1, 0);
    line(6, 4, 3);
    scen = "R8";
    repeat (20) tick(0);
    scen = "R9";
    slow = 1;
    line(6, 4, 4);
    repeat (40) tick(0);
    slow = 0;
    scen = "R3 R5";
    line(10, 3, 5);
    repeat (20) tick(0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule